// File: doc/BRIEF.md
# Panel Configuration Register Target

This block is the configuration port of a small TFT panel controller. A host talks to it over a four-wire serial link. Each transaction is two bytes long. The first byte names a register and says whether the host reads or writes it. The second byte carries the data, either sent by the host or returned by the block. The register file sits behind this link, and its contents drive parallel outputs that feed the display timing, power sequencing and gamma logic downstream. The block only stores the voltage, gamma and power settings and presents them on those outputs; nothing in it acts on them.

All serial inputs are brought into the system clock domain through two-stage synchronisers, and the serial clock edges are detected from the synchronised copy. The serial clock must therefore run at no more than about one eighth of the system clock. A register at the bottom of the map returns a fixed identification code. Writing a zero into bit 0 of the reset register puts the whole file back to its power-on values in a single cycle.

Top module: `panel_cfg_spi`

## Requirements
- R1: Serial mode 0 framing. `mosi` is sampled on rising `sck` edges, most significant bit first. `miso` changes after falling edges. In the first byte, bit 7 = 1 selects a read, bit 7 = 0 selects a write, and bits 6:0 give the register address.
- R2: In a write, the second byte is stored into the addressed register on the 16th rising `sck` edge. No register changes at any other time.
- R3: In a read, the addressed register's value is shifted out on `miso`, most significant bit first, during the second byte. `miso` is 0 whenever `cs_n` is high and outside the read data byte.
- R4: Address 0x00 always reads 0x96. Writes to address 0x00 change nothing.
- R5: After reset, the register values are 0x0F at 0x01, 0x2E at 0x02, 0x12 at 0x03, 0x01 at 0x04, 0x03 at 0x06 and 0x09 at 0x0A. Every other register is 0x00.
- R6: A write to 0x04 with data bit 0 = 0 restores every register to its R5 value. A write to 0x04 with bit 0 = 1 is stored like any other write.
- R7: Raising `cs_n` before the 16th rising edge abandons the transaction and leaves every register unchanged. The next transaction starts counting from bit 0.
- R8: Addresses 0x45 to 0x7F read as 0x00. Writes to those addresses change nothing. Address 0x44 is an ordinary read/write register.
- R9: The outputs map to registers as follows: `vcom_amp_o`=0x01, `vcom_high_o`=0x02, `vreg_o`=0x03, `entry_o`=0x06, `pwr_o`=0x07, `vbp_o`=0x08, `hbp_o`=0x09, `pol_o`=0x0A, `ifc_o`=0x0B. `gamma_o[8k+7:8k]` holds register 0x10+k, for k from 0 to 7.
- R10: Clock edges after the 16th rising edge of a selected transaction are ignored and change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial chip select, active low |
| sck | input | 1 | Serial clock from the host |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| vcom_amp_o | output | 8 | Register 0x01 |
| vcom_high_o | output | 8 | Register 0x02 |
| vreg_o | output | 8 | Register 0x03 |
| entry_o | output | 8 | Register 0x06 |
| pwr_o | output | 8 | Register 0x07 |
| vbp_o | output | 8 | Register 0x08 |
| hbp_o | output | 8 | Register 0x09 |
| pol_o | output | 8 | Register 0x0A |
| ifc_o | output | 8 | Register 0x0B |
| gamma_o | output | 64 | Registers 0x10 to 0x17 |

## Verification
Writes use alternating 0x55/0xAA data and distinct per-entry gamma bytes. A bit-order or byte-lane mistake would then land a visibly wrong value on the outputs and in the read-back. The address boundaries are tested directly: 0x00, 0x44 and 0x50. These separate the identification register and the last real register from an unimplemented address. Two ill-framed transactions check the bit counter at both ends. One is cut short at 12 bits, which must not store anything. The other runs to 20 bits, which must store the data once and ignore the surplus edges. Writes to 0x04 with bit 0 set and then cleared separate an ordinary store from a full restore to defaults.

// File: rtl/panel_cfg_spi.sv
module panel_cfg_spi #(
  parameter int          ADDR_MAX = 68,
  parameter logic [7:0]  CHIP_ID  = 8'h96
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cs_n,
  input  logic        sck,
  input  logic        mosi,
  output logic        miso,
  output logic [7:0]  vcom_amp_o,
  output logic [7:0]  vcom_high_o,
  output logic [7:0]  vreg_o,
  output logic [7:0]  entry_o,
  output logic [7:0]  pwr_o,
  output logic [7:0]  vbp_o,
  output logic [7:0]  hbp_o,
  output logic [7:0]  pol_o,
  output logic [7:0]  ifc_o,
  output logic [63:0] gamma_o
);
  localparam logic [6:0] AMAX    = ADDR_MAX[6:0];
  localparam logic [6:0] RST_REG = 7'd4;

  function automatic logic [7:0] dflt(input int a);
    case (a)
      1:       return 8'h0F;
      2:       return 8'h2E;
      3:       return 8'h12;
      4:       return 8'h01;
      6:       return 8'h03;
      10:      return 8'h09;
      default: return 8'h00;
    endcase
  endfunction

  logic [1:0] cs_q, mosi_q;
  logic [2:0] sck_q;
  logic [4:0] bitcnt;
  logic [6:0] sh;
  logic [6:0] addr;
  logic       rd;
  logic [7:0] tx;
  logic [7:0] rdval;
  logic [7:0] regs [0:ADDR_MAX];

  wire       cs_act   = ~cs_q[1];
  wire       sck_rise = sck_q[1] & ~sck_q[2];
  wire       sck_fall = ~sck_q[1] & sck_q[2];
  wire [7:0] shn      = {sh, mosi_q[1]};
  wire       wr_commit = cs_act & sck_rise & (bitcnt == 5'd15) & ~rd;
  wire       glob_rst  = wr_commit & (addr == RST_REG) & ~shn[0];
  wire       wr_ok     = wr_commit & (addr != 7'd0) & (addr <= AMAX);

  always_comb begin
    if (shn[6:0] == 7'd0)      rdval = CHIP_ID;
    else if (shn[6:0] > AMAX)  rdval = 8'h00;
    else                       rdval = regs[shn[6:0]];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q   <= 2'b11;
      sck_q  <= 3'b000;
      mosi_q <= 2'b00;
      bitcnt <= 5'd0;
      sh     <= 7'd0;
      addr   <= 7'd0;
      rd     <= 1'b0;
      tx     <= 8'h00;
    end else begin
      cs_q   <= {cs_q[0], cs_n};
      sck_q  <= {sck_q[1:0], sck};
      mosi_q <= {mosi_q[0], mosi};
      if (!cs_act) begin
        bitcnt <= 5'd0;
        tx     <= 8'h00;
      end else if (sck_rise && bitcnt != 5'd16) begin
        sh     <= shn[6:0];
        bitcnt <= bitcnt + 5'd1;
        if (bitcnt == 5'd7) begin
          addr <= shn[6:0];
          rd   <= shn[7];
          tx   <= shn[7] ? rdval : 8'h00;
        end
      end else if (sck_fall && bitcnt >= 5'd9 && bitcnt <= 5'd15) begin
        tx <= {tx[6:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i <= ADDR_MAX; i++) regs[i] <= dflt(i);
    end else if (glob_rst) begin
      for (int i = 0; i <= ADDR_MAX; i++) regs[i] <= dflt(i);
    end else if (wr_ok) begin
      regs[addr] <= shn;
    end
  end

  assign miso = cs_act & rd & (bitcnt >= 5'd8) & (bitcnt <= 5'd15) & tx[7];

  assign vcom_amp_o  = regs[1];
  assign vcom_high_o = regs[2];
  assign vreg_o      = regs[3];
  assign entry_o     = regs[6];
  assign pwr_o       = regs[7];
  assign vbp_o       = regs[8];
  assign hbp_o       = regs[9];
  assign pol_o       = regs[10];
  assign ifc_o       = regs[11];

  for (genvar g = 0; g < 8; g++) begin : g_gamma
    assign gamma_o[8*g +: 8] = regs[16+g];
  end

  assert_write_only_at_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_commit |=> ($stable(vcom_amp_o) && $stable(pol_o) && $stable(gamma_o)));

  assert_global_restore_R6: assert property (@(posedge clk) disable iff (!rst_n)
    glob_rst |=> (vcom_amp_o == 8'h0F && vcom_high_o == 8'h2E && vreg_o == 8'h12 &&
                  entry_o == 8'h03 && pol_o == 8'h09 && gamma_o == 64'd0));

  assert_abort_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> (bitcnt == 5'd0));

  assert_unmapped_write_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_commit && (addr == 7'd0 || addr > AMAX)) |=>
      ($stable(gamma_o) && $stable(pwr_o) && $stable(vcom_amp_o)));

  assert_miso_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cs_q[1] |-> !miso);

  assert_count_saturates_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bitcnt <= 5'd16);
endmodule

// File: tb/panel_cfg_spi_bench.sv
module panel_cfg_spi_bench;
  logic clk = 0, rst_n = 0, cs_n = 1, sck = 0, mosi = 0;
  logic miso;
  logic [7:0] vcom_amp_o, vcom_high_o, vreg_o, entry_o, pwr_o, vbp_o, hbp_o, pol_o, ifc_o;
  logic [63:0] gamma_o;

  int checks = 0, fails = 0;
  bit done = 0, chk_en = 0;
  logic [7:0] model [0:68];

  always #10 clk = ~clk;

  panel_cfg_spi u_panel_cfg_spi (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi), .miso(miso),
    .vcom_amp_o(vcom_amp_o), .vcom_high_o(vcom_high_o), .vreg_o(vreg_o),
    .entry_o(entry_o), .pwr_o(pwr_o), .vbp_o(vbp_o), .hbp_o(hbp_o),
    .pol_o(pol_o), .ifc_o(ifc_o), .gamma_o(gamma_o));

  task automatic model_defaults();
    for (int i = 0; i <= 68; i++) model[i] = 8'h00;
    model[1] = 8'h0F; model[2] = 8'h2E; model[3] = 8'h12;
    model[4] = 8'h01; model[6] = 8'h03; model[10] = 8'h09;
  endtask

  task automatic model_write(input logic [6:0] a, input logic [7:0] d);
    if (a == 7'd4 && !d[0]) model_defaults();
    else if (a != 0 && a <= 7'd68) model[a] = d;
  endtask

  function automatic logic [7:0] model_read(input logic [6:0] a);
    if (a == 0) return 8'h96;
    if (a > 7'd68) return 8'h00;
    return model[a];
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // R9: every clock while idle, outputs must equal the behavioural register model
  always @(negedge clk) if (chk_en && !done) begin
    check("R9 outputs", {vcom_amp_o, vcom_high_o, vreg_o, entry_o, pwr_o, vbp_o, hbp_o, pol_o},
          {model[1], model[2], model[3], model[6], model[7], model[8], model[9], model[10]});
    check("R9 gamma", gamma_o, {model[23], model[22], model[21], model[20],
                                model[19], model[18], model[17], model[16]});
    check("R9 ifc", {56'd0, ifc_o}, {56'd0, model[11]});
    if (cs_n) check("R3 miso idle", {63'd0, miso}, 64'd0);
  end

  task automatic xfer(input logic [7:0] b0, input logic [7:0] b1, input int nbits,
                      output logic [7:0] rx);
    logic [15:0] frame;
    frame = {b0, b1};
    rx = 8'h00;
    chk_en = 0;
    @(negedge clk); cs_n = 0;
    repeat (4) @(negedge clk);
    for (int k = 0; k < nbits; k++) begin
      mosi = (k < 16) ? frame[15-k] : 1'b1;
      repeat (4) @(negedge clk);
      if (k >= 8 && k < 16) rx = {rx[6:0], miso};
      sck = 1;
      repeat (4) @(negedge clk);
      sck = 0;
    end
    repeat (4) @(negedge clk);
    cs_n = 1;
    repeat (6) @(negedge clk);
  endtask

  task automatic wr(input logic [6:0] a, input logic [7:0] d);
    logic [7:0] rx;
    xfer({1'b0, a}, d, 16, rx);
    model_write(a, d);
    chk_en = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic rd_chk(input string req, input logic [6:0] a);
    logic [7:0] rx;
    xfer({1'b1, a}, 8'h00, 16, rx);
    check(req, {56'd0, rx}, {56'd0, model_read(a)});
    chk_en = 1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] rx;
    model_defaults();
    repeat (3) @(negedge clk);
    check("R3 miso in reset", {63'd0, miso}, 64'd0);
    rst_n = 1;
    chk_en = 1;
    repeat (5) @(negedge clk);
    // R5 defaults, read back over R1/R3 framing
    rd_chk("R5 default 0x01", 7'h01);
    rd_chk("R5 default 0x0A", 7'h0A);
    rd_chk("R5 default 0x06", 7'h06);
    rd_chk("R4 id", 7'h00);
    // R2/R9 writes with alternating patterns
    wr(7'h0A, 8'h55); rd_chk("R2 pol 55", 7'h0A);
    wr(7'h0A, 8'hAA); rd_chk("R1 pol AA", 7'h0A);
    wr(7'h07, 8'hA5); rd_chk("R2 pwr", 7'h07);
    for (int g = 0; g < 8; g++) wr(7'h10 + 7'(g), 8'(8'h11 * (g + 1)) ^ 8'h80);
    rd_chk("R9 gamma 0x10", 7'h10);
    rd_chk("R9 gamma 0x17", 7'h17);
    wr(7'h08, 8'h3F); wr(7'h09, 8'hC3); wr(7'h0B, 8'h0D);
    // R4 id write ignored
    wr(7'h00, 8'h12); rd_chk("R4 id after write", 7'h00);
    // R8 boundary and unmapped
    wr(7'h44, 8'h3C); rd_chk("R8 last reg", 7'h44);
    wr(7'h50, 8'hFF); rd_chk("R8 unmapped read", 7'h50);
    rd_chk("R8 top addr", 7'h7F);
    // R7 abort mid-transaction
    xfer(8'h01, 8'h77, 12, rx);
    chk_en = 1; repeat (3) @(negedge clk);
    rd_chk("R7 abort no change", 7'h01);
    // R10 extra edges ignored
    xfer(8'h02, 8'h40, 20, rx);
    model_write(7'h02, 8'h40);
    chk_en = 1; repeat (3) @(negedge clk);
    rd_chk("R10 extra bits", 7'h02);
    // R6 reset register
    wr(7'h04, 8'h81); rd_chk("R6 store bit0 set", 7'h04);
    rd_chk("R6 no restore", 7'h07);
    wr(7'h04, 8'h00);
    rd_chk("R6 restored 0x07", 7'h07);
    rd_chk("R6 restored 0x03", 7'h03);
    rd_chk("R6 restored 0x44", 7'h44);
    repeat (10) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule